// File: doc/BRIEF.md
# Pulse-Width Channel with Boundary-Synchronised Update

This block generates one pulse-width modulated waveform from a free-running period counter. The counter advances on prescaled ticks, where the tick rate is the system clock divided by a power of two chosen by a four-bit select field. A comparator sets the waveform's level, and a polarity bit chooses which level counts as active. The duty register holds the number of counts at the start of each period during which the output stays at the inactive level. The output is active for the rest of the period.

A single shadow update register lets the waveform be retuned while the channel runs. A write to it is not applied at once. It is copied into either the duty register or the period register at the next period boundary, so that no period ever mixes two settings. A mode bit chooses which of the two registers receives the value. An update-pending flag shows that a write is waiting. A one-cycle pulse marks each period start, and that pulse is the moment the queued value takes effect. The initial period and duty values are captured when the channel is enabled. The register width is 16 bits by default, and a parameter widens it to 32 bits.

Top module: `pwmb_channel`

## Requirements
- R1: During reset and after it, with the channel disabled and mode bit 9 low, `pwm_o`, `cycle_start_o` and `upd_pending_o` are all 0.
- R2: The counter advances once every 2^P clocks, where P is `mode_i[3:0]`. Select values above 10 behave as 10. A period therefore lasts max(PRD,1)·2^P clocks.
- R3: Each period starts at the inactive level and stays there for DUTY counts, then is active for the remaining counts. DUTY = 0 gives a fully active period. DUTY ≥ PRD gives a fully inactive period.
- R4: `mode_i[9]` = 1 inverts the output, so the inactive level equals `mode_i[9]`.
- R5: While `chan_en_i` is low, the output sits at the inactive level, no period-start pulse appears, the pending flag is clear and the counter is held at zero. Update writes made while the channel is disabled, or in its first enabled cycle, are ignored.
- R6: `period_i` and `duty_i` are captured in the first enabled cycle, which also carries a period-start pulse. Later changes to them while the channel runs have no effect.
- R7: `cycle_start_o` is high for exactly one clock at the first clock of every period.
- R8: `upd_pending_o` rises in the clock after an accepted `upd_wr_i` and falls at the next period start, unless another write arrived in the clock before it.
- R9: A queued value takes effect at the next period start and not earlier. If `mode_i[10]` is 0 at that moment it loads the duty register, and if it is 1 it loads the period register.
- R10: A write sampled at a period boundary is not applied at that boundary. It stays pending and is applied at the following boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| chan_en_i | input | 1 | Channel run enable |
| mode_i | input | 11 | [3:0] prescale select, [9] polarity, [10] update target |
| period_i | input | CNT_W (16) | Initial period in counts |
| duty_i | input | CNT_W (16) | Initial inactive count |
| upd_val_i | input | CNT_W (16) | Value for the shadow update register |
| upd_wr_i | input | 1 | Write strobe for the shadow update register |
| pwm_o | output | 1 | Waveform |
| cycle_start_o | output | 1 | One-clock pulse at each period start |
| upd_pending_o | output | 1 | A shadow value waits for the next boundary |

## Verification
The assertions assume that `mode_i` is stable while the channel runs, except for the target bit, and that the period register holds a nonzero value wherever a duty-versus-period comparison is asserted. The bench changes the prescale select and polarity only while the channel is disabled. It keeps random periods between 1 and 12 and random duties between 0 and 14, so both the saturated cases and the ordinary split occur. Update writes are issued at random points, including the last clock of a period, and each write picks its target at random.

// File: rtl/pwmb_pkg.sv
package pwmb_pkg;
   localparam int MODE_W    = 11;
   localparam int PRE_LSB   = 0;
   localparam int PRE_W     = 4;
   localparam int POL_BIT   = 9;
   localparam int TGT_BIT   = 10;
   localparam int MAX_PRE   = 10;

   typedef enum logic {
      TGT_DUTY   = 1'b0,
      TGT_PERIOD = 1'b1
   } upd_tgt_e;

   function automatic logic [PRE_W-1:0] clamp_pre(input logic [PRE_W-1:0] sel,
                                                  input int unsigned      lim);
      if (int'(sel) > int'(lim)) return PRE_W'(lim);
      return sel;
   endfunction
endpackage

// File: rtl/pwmb_prescale.sv
module pwmb_prescale #(
   parameter int SEL_W   = 4,
   parameter int MAX_SEL = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);
   if (MAX_SEL >= (1 << SEL_W)) begin : g_bad_sel
      $error("pwmb_prescale: MAX_SEL does not fit the select field");
   end

   if (MAX_SEL == 0) begin : g_nodiv
      assign tick_o = run_i;
   end else begin : g_div
      localparam int DIV_W = MAX_SEL;
      logic [DIV_W-1:0] div_q;
      logic [DIV_W-1:0] mask;
      logic [SEL_W-1:0] sel_c;

      always_comb begin
         sel_c = pwmb_pkg::clamp_pre(sel_i, MAX_SEL);
         for (int i = 0; i < DIV_W; i++) begin
            mask[i] = (i < int'(sel_c));
         end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)     div_q <= '0;
         else if (!run_i) div_q <= '0;
         else             div_q <= div_q + 1'b1;
      end

      assign tick_o = run_i && ((div_q & mask) == mask);
   end
endmodule

// File: rtl/pwmb_counter.sv
module pwmb_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             chan_en_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] prd_i,
   output logic             en_q_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             load_o,
   output logic             start_o
);
   logic             en_q;
   logic             start_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   cnt_inc;
   logic [CNT_W:0]   prd_eff;
   logic             wrap;

   assign cnt_inc = {1'b0, cnt_q} + 1'b1;
   assign prd_eff = (prd_i == '0) ? (CNT_W+1)'(1) : {1'b0, prd_i};
   assign wrap    = en_q && tick_i && (cnt_inc >= prd_eff);
   assign load_o  = chan_en_i && (!en_q || wrap);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q    <= 1'b0;
         start_q <= 1'b0;
         cnt_q   <= '0;
      end else if (!chan_en_i) begin
         en_q    <= 1'b0;
         start_q <= 1'b0;
         cnt_q   <= '0;
      end else begin
         en_q    <= 1'b1;
         start_q <= load_o;
         if (load_o)      cnt_q <= '0;
         else if (tick_i) cnt_q <= cnt_inc[CNT_W-1:0];
      end
   end

   assign en_q_o  = en_q;
   assign cnt_o   = cnt_q;
   assign start_o = start_q;
endmodule

// File: rtl/pwmb_shadow.sv
module pwmb_shadow #(
   parameter int CNT_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              chan_en_i,
   input  logic              en_q_i,
   input  logic              load_i,
   input  pwmb_pkg::upd_tgt_e tgt_i,
   input  logic [CNT_W-1:0]  period_i,
   input  logic [CNT_W-1:0]  duty_i,
   input  logic [CNT_W-1:0]  upd_val_i,
   input  logic              upd_wr_i,
   output logic [CNT_W-1:0]  prd_o,
   output logic [CNT_W-1:0]  duty_o,
   output logic              pend_o
);
   logic [CNT_W-1:0] prd_q, duty_q, shd_q;
   logic             pend_q;
   logic             apply;

   assign apply = en_q_i && load_i && pend_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prd_q  <= '0;
         duty_q <= '0;
         shd_q  <= '0;
         pend_q <= 1'b0;
      end else if (!chan_en_i) begin
         pend_q <= 1'b0;
      end else if (!en_q_i) begin
         prd_q  <= period_i;
         duty_q <= duty_i;
         pend_q <= 1'b0;
      end else begin
         if (apply) begin
            if (tgt_i == pwmb_pkg::TGT_PERIOD) prd_q  <= shd_q;
            else                               duty_q <= shd_q;
         end
         if (upd_wr_i) begin
            shd_q  <= upd_val_i;
            pend_q <= 1'b1;
         end else if (load_i) begin
            pend_q <= 1'b0;
         end
      end
   end

   assign prd_o  = prd_q;
   assign duty_o = duty_q;
   assign pend_o = pend_q;
endmodule

// File: rtl/pwmb_channel.sv
module pwmb_channel #(
   parameter bit WIDE  = 1'b0,
   parameter int CNT_W = WIDE ? 32 : 16
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       chan_en_i,
   input  logic [pwmb_pkg::MODE_W-1:0] mode_i,
   input  logic [CNT_W-1:0]           period_i,
   input  logic [CNT_W-1:0]           duty_i,
   input  logic [CNT_W-1:0]           upd_val_i,
   input  logic                       upd_wr_i,
   output logic                       pwm_o,
   output logic                       cycle_start_o,
   output logic                       upd_pending_o
);
   import pwmb_pkg::*;

   if (CNT_W != (WIDE ? 32 : 16)) begin : g_bad_width
      $error("pwmb_channel: CNT_W must follow WIDE (16 or 32)");
   end

   logic             en_q;
   logic             tick;
   logic             load;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] prd_q;
   logic [CNT_W-1:0] duty_q;
   logic             cpol;
   upd_tgt_e         tgt;

   assign cpol = mode_i[POL_BIT];
   assign tgt  = upd_tgt_e'(mode_i[TGT_BIT]);

   pwmb_prescale #(
      .SEL_W  (PRE_W),
      .MAX_SEL(MAX_PRE)
   ) u_pre (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .run_i (en_q),
      .sel_i (mode_i[PRE_LSB +: PRE_W]),
      .tick_o(tick)
   );

   pwmb_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .chan_en_i(chan_en_i),
      .tick_i   (tick),
      .prd_i    (prd_q),
      .en_q_o   (en_q),
      .cnt_o    (cnt_q),
      .load_o   (load),
      .start_o  (cycle_start_o)
   );

   pwmb_shadow #(.CNT_W(CNT_W)) u_shd (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .chan_en_i(chan_en_i),
      .en_q_i   (en_q),
      .load_i   (load),
      .tgt_i    (tgt),
      .period_i (period_i),
      .duty_i   (duty_i),
      .upd_val_i(upd_val_i),
      .upd_wr_i (upd_wr_i),
      .prd_o    (prd_q),
      .duty_o   (duty_q),
      .pend_o   (upd_pending_o)
   );

   assign pwm_o = cpol ^ (en_q && (cnt_q >= duty_q));
endmodule

// File: rtl/pwmb_channel_chk.sv
module pwmb_channel_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             chan_en_i,
   input logic [10:0]      mode_i,
   input logic             upd_wr_i,
   input logic             pwm_o,
   input logic             cycle_start_o,
   input logic             upd_pending_o,
   input logic             en_q,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] prd_q,
   input logic [CNT_W-1:0] duty_q
);
   assert_idle_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_q |-> (pwm_o == mode_i[9]) && !cycle_start_o && !upd_pending_o);

   assert_start_at_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cycle_start_o |-> (cnt_q == '0));

   assert_start_inactive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cycle_start_o && duty_q != '0) |-> (pwm_o == mode_i[9]));

   assert_duty_saturate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_q && prd_q != '0 && duty_q >= prd_q) |-> (pwm_o == mode_i[9]));

   assert_pend_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_q && chan_en_i && upd_wr_i) |=> upd_pending_o);

   assert_pend_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(upd_pending_o) |-> (cycle_start_o || !en_q));
endmodule

bind pwmb_channel pwmb_channel_chk #(.CNT_W(CNT_W)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .chan_en_i    (chan_en_i),
   .mode_i       (mode_i),
   .upd_wr_i     (upd_wr_i),
   .pwm_o        (pwm_o),
   .cycle_start_o(cycle_start_o),
   .upd_pending_o(upd_pending_o),
   .en_q         (en_q),
   .cnt_q        (cnt_q),
   .prd_q        (prd_q),
   .duty_q       (duty_q)
);

// File: tb/pwmb_channel_bench.sv
module pwmb_channel_bench;
   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        chan_en_i = 1'b0;
   logic [10:0] mode_i = '0;
   logic [15:0] period_i = '0, duty_i = '0, upd_val_i = '0;
   logic        upd_wr_i = 1'b0;
   logic        pwm_o, cycle_start_o, upd_pending_o;

   int checks = 0, fails = 0;
   bit done = 0;
   string sect = "init";

   longint nin, mprd, mduty, mshd;
   bit     mrun, mpend;

   always #10 clk_i = ~clk_i;

   pwmb_channel u_pwmb_channel (
      .clk_i(clk_i), .rst_ni(rst_ni), .chan_en_i(chan_en_i), .mode_i(mode_i),
      .period_i(period_i), .duty_i(duty_i), .upd_val_i(upd_val_i),
      .upd_wr_i(upd_wr_i), .pwm_o(pwm_o), .cycle_start_o(cycle_start_o),
      .upd_pending_o(upd_pending_o));

   function automatic int pe_of(input logic [3:0] s);
      return (s > 4'd10) ? 10 : int'(s);
   endfunction

   function automatic longint plen();
      return ((mprd == 0) ? 64'd1 : mprd) << pe_of(mode_i[3:0]);
   endfunction

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", req, sect, act, exp, $time);
      end
   endtask

   task automatic advance();
      bit bnd;
      if (!chan_en_i) begin
         mrun = 0; mpend = 0; nin = 0;
      end else if (!mrun) begin
         mrun = 1; nin = 0; mprd = period_i; mduty = duty_i; mpend = 0;
      end else begin
         bnd = 0;
         if (nin + 1 >= plen()) begin nin = 0; bnd = 1; end
         else nin++;
         if (bnd && mpend) begin
            if (mode_i[10]) mprd = mshd; else mduty = mshd;
         end
         if (upd_wr_i) begin mshd = upd_val_i; mpend = 1; end
         else if (bnd) mpend = 0;
      end
   endtask

   task automatic compare();
      bit ew;
      ew = mode_i[9] ^ (mrun && ((nin >> pe_of(mode_i[3:0])) >= mduty));
      check(mode_i[9] ? "R4" : "R3", pwm_o, ew);
      check("R7", cycle_start_o, mrun && nin == 0);
      check("R8", upd_pending_o, mpend);
   endtask

   task automatic step(input bit wr, input logic [15:0] v);
      upd_wr_i = wr; upd_val_i = v;
      @(posedge clk_i);
      advance();
      @(negedge clk_i);
      compare();
      upd_wr_i = 1'b0;
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 16'd0);
   endtask

   task automatic start(input logic [10:0] m, input int p, input int d);
      chan_en_i = 1'b0; run(2);
      mode_i = m; period_i = 16'(p); duty_i = 16'(d);
      chan_en_i = 1'b1;
   endtask

   initial begin
      int starts;
      void'($urandom(32'd1357));
      mrun = 0; mpend = 0; nin = 0; mprd = 0; mduty = 0; mshd = 0;
      @(negedge clk_i);
      sect = "R1";
      check("R1", pwm_o, 0); check("R1", cycle_start_o, 0); check("R1", upd_pending_o, 0);
      repeat (3) @(negedge clk_i);
      rst_ni = 1'b1;
      run(3);
      check("R1", pwm_o, 0);

      sect = "R6 basic";
      start(11'h000, 5, 2); run(16);
      period_i = 16'd9; duty_i = 16'd7; run(12);

      sect = "R3 duty zero";   start(11'h000, 4, 0); run(10);
      sect = "R3 duty over";   start(11'h000, 4, 6); run(10);
      sect = "R4 inverted";    start(11'h200, 6, 2); run(14);
      sect = "R2 prescale 3";  start(11'h003, 3, 1); run(60);

      sect = "R2 clamp";
      start(11'h00F, 2, 1);
      starts = 0;
      for (int i = 0; i < 4100; i++) begin
         step(1'b0, 16'd0);
         if (cycle_start_o) starts++;
      end
      check("R2", starts, 3);

      sect = "R5 disabled";
      chan_en_i = 1'b0; run(2);
      mode_i = 11'h000; period_i = 16'd5; duty_i = 16'd3;
      step(1'b1, 16'd1); run(1);
      check("R5", upd_pending_o, 0); check("R5", pwm_o, 0);
      chan_en_i = 1'b1;
      step(1'b1, 16'd0);
      check("R5", upd_pending_o, 0);
      run(12);

      sect = "R9 duty update";
      start(11'h000, 8, 2); run(3);
      step(1'b1, 16'd6); run(12);
      sect = "R9 period update";
      mode_i[10] = 1'b1; step(1'b1, 16'd3); run(14);
      mode_i[10] = 1'b0;

      sect = "R10 boundary write";
      start(11'h000, 4, 1); run(2);
      while (nin != plen() - 1) step(1'b0, 16'd0);
      step(1'b1, 16'd3);
      check("R10", cycle_start_o, 1);
      check("R10", upd_pending_o, 1);
      run(10);

      sect = "random";
      for (int r = 0; r < 24; r++) begin
         start({1'b0, 1'($urandom % 2), 5'd0, 4'($urandom % 3)},
               1 + int'($urandom % 12), int'($urandom % 15));
         for (int c = 0; c < 50; c++) begin
            if ($urandom % 8 == 0) begin
               mode_i[10] = 1'($urandom % 2);
               step(1'b1, mode_i[10] ? 16'(1 + $urandom % 12) : 16'($urandom % 15));
            end else step(1'b0, 16'd0);
         end
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule